// File: doc/BRIEF.md
# Chip-Select Decode and Match Resolver

This block sits in the address path of a bus controller. Every bus cycle offers the upper half of its address, a read/write flag and a CPU-space flag. The block compares that against eight programmable chip-select windows and two DRAM block windows. Each window has a base and a don't-care mask. From the number and kind of windows that hit, it picks the cycle type. It returns the chip-select strobes, the DRAM block select, the port size, the burst permission, the termination mode, the wait-state count and a flag for undefined cycles.

Requests arrive on a valid/ready stream and results leave on a valid/ready stream through one output register. A request is taken in any cycle where `req_valid` and `req_ready` are both high. `req_ready` is high when the output register is empty or is being emptied in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no new request is taken. Window registers are written through a plain write port that is not flow-controlled. A write takes effect from the next clock edge. A request accepted on the same edge as a write is decoded with the old settings.

Chip select 0 starts as a boot select. From reset until its control register is first written, it claims every normal-space cycle with fixed boot attributes. This lets a boot ROM be reached before any window is programmed.

Top module: `csd_decoder`

## Requirements
- R1: A window hits when ((req_addr_hi XOR base) AND NOT mask) is zero and its valid bit is set. A mask bit of 1 marks a don't-care address bit. A chip-select window with its write-protect bit set never hits a write cycle.
- R2: On a CPU-space cycle (`req_cpu_space`=1), a chip-select window hits only if its CPU-space enable bit is set. A DRAM window never hits a CPU-space cycle. On normal cycles the CPU-space enable bit has no effect.
- R3: From reset until the first write to chip select 0's control register (cfg_addr 1), chip select 0 hits every normal-space cycle and no CPU-space cycle, whatever its base, mask and valid bit hold. Its single-hit attributes in that mode are port size 00, burst 0, auto-acknowledge 1 and wait count BOOT_WAIT (15).
- R4: With no hit at all, the response has all strobes low, port size 00 (32-bit), burst 0, auto-acknowledge 0 (external termination), wait 0 and undef 0.
- R5: With exactly one chip-select hit and no DRAM hit, only that strobe is high. Port size, burst, auto-acknowledge and wait count are taken from its control register. Port size encoding: 00 = 32-bit, 01 = 8-bit, 10 = 16-bit.
- R6: With two or more chip-select hits and no DRAM hit, every hitting strobe is high. Port size is forced to 00, burst to 0, auto-acknowledge to 0 and wait to 0.
- R7: With exactly one DRAM hit and no chip-select hit, that DRAM select bit is high and no strobe is. Port size and burst come from that DRAM block's control register. Auto-acknowledge is 1 and wait is 0.
- R8: Any DRAM hit together with a chip-select hit, or hits on both DRAM blocks, sets undef to 1. In that case all strobes and DRAM selects are low, port size is 00, and burst, auto-acknowledge and wait are 0.
- R9: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. The response for an accepted request appears in the following cycle. While `rsp_valid` is high and `rsp_ready` is low, every response field holds.
- R10: Register map. cfg_addr[4:1] is the window index: 0–7 are chip selects, 8–9 are DRAM blocks, and 10–15 are ignored. cfg_addr[0]=0 writes base (wdata[31:16]) and mask (wdata[15:0]). cfg_addr[0]=1 writes control: bit 0 valid, bit 1 CPU-space enable, bit 2 write-protect, bits 5:4 port size, bit 6 burst, bit 7 auto-acknowledge, bits 11:8 wait count. DRAM control uses only bits 0, 5:4 and 6.
- R11: During reset `rsp_valid` is 0 and `req_ready` is 1. All windows reset to invalid, with zero base and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Window index and register select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr_hi | input | 16 | Address bits 31:16 of the bus cycle |
| req_write | input | 1 | 1 for a write cycle |
| req_cpu_space | input | 1 | 1 for a CPU-space cycle (for example interrupt acknowledge) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_cs | output | 8 | Chip-select strobes, active high |
| rsp_dram_sel | output | 2 | DRAM block select |
| rsp_port_size | output | 2 | 00 32-bit, 01 8-bit, 10 16-bit |
| rsp_burst_en | output | 1 | Burst permitted |
| rsp_auto_ack | output | 1 | 1 internal termination, 0 external |
| rsp_wait | output | 4 | Wait-state count |
| rsp_undef | output | 1 | Undefined match combination |

## Verification
A window register, or a boot flag that clears at the wrong moment, shows up at the ports as a wrong strobe or a wrong attribute set. This appears in the response cycle that follows the first request touching that window. To expose such faults, the requests are placed on window edges, on overlaps and on both address spaces. A miscounted match class shows up as attributes that are not forced on a multi-hit, or as a missing undef flag, again one cycle after acceptance. A faulty hold register is exposed by comparing under random back-pressure, because the fault appears as a response field that changes while `rsp_ready` is low.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int CMP_W  = 16;
  localparam int WAIT_W = 4;

  typedef enum logic [1:0] {
    PS_32 = 2'b00,
    PS_8  = 2'b01,
    PS_16 = 2'b10
  } port_size_e;

  // attributes a finished decode hands to the bus sequencer
  typedef struct packed {
    port_size_e          port_size;
    logic                burst;
    logic                auto_ack;
    logic [WAIT_W-1:0]   wait_st;
  } cyc_attr_t;

  typedef struct packed {
    logic       valid;
    logic       cpu_en;
    logic       wr_prot;
    cyc_attr_t  attr;
  } cs_ctrl_t;

  typedef struct packed {
    logic        valid;
    port_size_e  port_size;
    logic        burst;
  } dr_ctrl_t;

  localparam cyc_attr_t EXT_ATTR = '{port_size: PS_32, burst: 1'b0,
                                     auto_ack: 1'b0, wait_st: '0};
endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
  import csd_pkg::*;
#(
  parameter int N_CS   = 8,
  parameter int N_DRAM = 2,
  parameter int CFG_AW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [2*CMP_W-1:0] cfg_wdata,
  output logic [CMP_W-1:0]   cs_base [N_CS],
  output logic [CMP_W-1:0]   cs_mask [N_CS],
  output cs_ctrl_t           cs_ctrl [N_CS],
  output logic [CMP_W-1:0]   dr_base [N_DRAM],
  output logic [CMP_W-1:0]   dr_mask [N_DRAM],
  output dr_ctrl_t           dr_ctrl [N_DRAM],
  output logic               boot_active
);
  localparam int IDX_W = CFG_AW - 1;

  logic [IDX_W-1:0] wr_idx;
  logic             wr_ctl;

  assign wr_idx = cfg_addr[CFG_AW-1:1];
  assign wr_ctl = cfg_addr[0];

  // chip-select window storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CS; i++) begin
        cs_base[i] <= '0;
        cs_mask[i] <= '0;
        cs_ctrl[i] <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < N_CS; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          if (wr_ctl) begin
            cs_ctrl[i].valid          <= cfg_wdata[0];
            cs_ctrl[i].cpu_en         <= cfg_wdata[1];
            cs_ctrl[i].wr_prot        <= cfg_wdata[2];
            cs_ctrl[i].attr.port_size <= port_size_e'(cfg_wdata[5:4]);
            cs_ctrl[i].attr.burst     <= cfg_wdata[6];
            cs_ctrl[i].attr.auto_ack  <= cfg_wdata[7];
            cs_ctrl[i].attr.wait_st   <= cfg_wdata[8 +: WAIT_W];
          end else begin
            cs_base[i] <= cfg_wdata[2*CMP_W-1:CMP_W];
            cs_mask[i] <= cfg_wdata[CMP_W-1:0];
          end
        end
      end
    end
  end

  // DRAM block window storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N_DRAM; j++) begin
        dr_base[j] <= '0;
        dr_mask[j] <= '0;
        dr_ctrl[j] <= '0;
      end
    end else if (cfg_we) begin
      for (int j = 0; j < N_DRAM; j++) begin
        if (wr_idx == IDX_W'(N_CS + j)) begin
          if (wr_ctl) begin
            dr_ctrl[j].valid     <= cfg_wdata[0];
            dr_ctrl[j].port_size <= port_size_e'(cfg_wdata[5:4]);
            dr_ctrl[j].burst     <= cfg_wdata[6];
          end else begin
            dr_base[j] <= cfg_wdata[2*CMP_W-1:CMP_W];
            dr_mask[j] <= cfg_wdata[CMP_W-1:0];
          end
        end
      end
    end
  end

  // boot select stays on until chip select 0 gets its control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      boot_active <= 1'b1;
    else if (cfg_we && wr_ctl && wr_idx == '0)
      boot_active <= 1'b0;
  end
endmodule

// File: rtl/csd_win_match.sv
module csd_win_match
  import csd_pkg::*;
(
  input  logic [CMP_W-1:0] addr_hi,
  input  logic [CMP_W-1:0] base,
  input  logic [CMP_W-1:0] mask,
  input  logic             win_valid,
  input  logic             cpu_en,
  input  logic             wr_prot,
  input  logic             force_hit,
  input  logic             req_write,
  input  logic             req_cpu_space,
  output logic             hit
);
  logic [CMP_W-1:0] diff;
  logic             in_win;
  logic             space_ok;
  logic             access_ok;

  assign diff      = (addr_hi ^ base) & ~mask;
  assign in_win    = win_valid && (diff == '0);
  assign space_ok  = !req_cpu_space || cpu_en;
  assign access_ok = !(req_write && wr_prot);

  always_comb begin
    if (force_hit)
      hit = !req_cpu_space;
    else
      hit = in_win && space_ok && access_ok;
  end
endmodule

// File: rtl/csd_resolve.sv
module csd_resolve
  import csd_pkg::*;
#(
  parameter int N_CS   = 8,
  parameter int N_DRAM = 2
) (
  input  logic [N_CS-1:0]   cs_hit,
  input  logic [N_DRAM-1:0] dr_hit,
  input  cyc_attr_t         cs_attr [N_CS],
  input  cyc_attr_t         dr_attr [N_DRAM],
  output logic [N_CS-1:0]   cs_out,
  output logic [N_DRAM-1:0] dr_out,
  output cyc_attr_t         attr_out,
  output logic              undef
);
  localparam int CS_CW = $clog2(N_CS + 1);
  localparam int DR_CW = $clog2(N_DRAM + 1);
  localparam int CS_IW = (N_CS > 1) ? $clog2(N_CS) : 1;
  localparam int DR_IW = (N_DRAM > 1) ? $clog2(N_DRAM) : 1;

  logic [CS_CW-1:0] n_cs;
  logic [DR_CW-1:0] n_dr;
  logic [CS_IW-1:0] cs_idx;
  logic [DR_IW-1:0] dr_idx;

  always_comb begin
    n_cs   = '0;
    cs_idx = '0;
    for (int i = 0; i < N_CS; i++) begin
      if (cs_hit[i]) begin
        n_cs   = n_cs + CS_CW'(1);
        cs_idx = CS_IW'(i);
      end
    end
    n_dr   = '0;
    dr_idx = '0;
    for (int j = 0; j < N_DRAM; j++) begin
      if (dr_hit[j]) begin
        n_dr   = n_dr + DR_CW'(1);
        dr_idx = DR_IW'(j);
      end
    end
  end

  always_comb begin
    cs_out   = '0;
    dr_out   = '0;
    attr_out = EXT_ATTR;
    undef    = 1'b0;
    if (n_dr == '0) begin
      cs_out = cs_hit;
      if (n_cs == CS_CW'(1))
        attr_out = cs_attr[cs_idx];
    end else if (n_dr == DR_CW'(1) && n_cs == '0) begin
      dr_out   = dr_hit;
      attr_out = dr_attr[dr_idx];
    end else begin
      undef = 1'b1;
    end
  end
endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
  import csd_pkg::*;
#(
  parameter int         N_CS      = 8,
  parameter int         N_DRAM    = 2,
  parameter int         BOOT_WAIT = 15,
  parameter logic [1:0] BOOT_PS   = 2'b00,
  localparam int        N_WIN     = N_CS + N_DRAM,
  localparam int        CFG_AW    = $clog2(N_WIN) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [2*CMP_W-1:0] cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CMP_W-1:0]   req_addr_hi,
  input  logic               req_write,
  input  logic               req_cpu_space,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [N_CS-1:0]    rsp_cs,
  output logic [N_DRAM-1:0]  rsp_dram_sel,
  output logic [1:0]         rsp_port_size,
  output logic               rsp_burst_en,
  output logic               rsp_auto_ack,
  output logic [WAIT_W-1:0]  rsp_wait,
  output logic               rsp_undef
);
  localparam cyc_attr_t BOOT_ATTR = '{port_size: port_size_e'(BOOT_PS), burst: 1'b0,
                                      auto_ack: 1'b1, wait_st: WAIT_W'(BOOT_WAIT)};

  logic [CMP_W-1:0] cs_base [N_CS];
  logic [CMP_W-1:0] cs_mask [N_CS];
  cs_ctrl_t         cs_ctrl [N_CS];
  logic [CMP_W-1:0] dr_base [N_DRAM];
  logic [CMP_W-1:0] dr_mask [N_DRAM];
  dr_ctrl_t         dr_ctrl [N_DRAM];
  logic             boot_active;

  logic [N_CS-1:0]   cs_hit;
  logic [N_DRAM-1:0] dr_hit;
  cyc_attr_t         cs_attr [N_CS];
  cyc_attr_t         dr_attr [N_DRAM];

  logic [N_CS-1:0]   nxt_cs;
  logic [N_DRAM-1:0] nxt_dr;
  cyc_attr_t         nxt_attr;
  logic              nxt_undef;
  logic              take;

  csd_cfg_regs #(.N_CS(N_CS), .N_DRAM(N_DRAM), .CFG_AW(CFG_AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cs_base     (cs_base),
    .cs_mask     (cs_mask),
    .cs_ctrl     (cs_ctrl),
    .dr_base     (dr_base),
    .dr_mask     (dr_mask),
    .dr_ctrl     (dr_ctrl),
    .boot_active (boot_active)
  );

  for (genvar i = 0; i < N_CS; i++) begin : g_cs_win
    logic boot_here;
    if (i == 0) begin : g_boot
      assign boot_here = boot_active;
      assign cs_attr[i] = boot_active ? BOOT_ATTR : cs_ctrl[i].attr;
    end else begin : g_plain
      assign boot_here = 1'b0;
      assign cs_attr[i] = cs_ctrl[i].attr;
    end
    csd_win_match u_match (
      .addr_hi       (req_addr_hi),
      .base          (cs_base[i]),
      .mask          (cs_mask[i]),
      .win_valid     (cs_ctrl[i].valid),
      .cpu_en        (cs_ctrl[i].cpu_en),
      .wr_prot       (cs_ctrl[i].wr_prot),
      .force_hit     (boot_here),
      .req_write     (req_write),
      .req_cpu_space (req_cpu_space),
      .hit           (cs_hit[i])
    );
  end

  for (genvar j = 0; j < N_DRAM; j++) begin : g_dr_win
    assign dr_attr[j] = '{port_size: dr_ctrl[j].port_size, burst: dr_ctrl[j].burst,
                          auto_ack: 1'b1, wait_st: '0};
    csd_win_match u_match (
      .addr_hi       (req_addr_hi),
      .base          (dr_base[j]),
      .mask          (dr_mask[j]),
      .win_valid     (dr_ctrl[j].valid),
      .cpu_en        (1'b0),
      .wr_prot       (1'b0),
      .force_hit     (1'b0),
      .req_write     (req_write),
      .req_cpu_space (req_cpu_space),
      .hit           (dr_hit[j])
    );
  end

  csd_resolve #(.N_CS(N_CS), .N_DRAM(N_DRAM)) u_resolve (
    .cs_hit   (cs_hit),
    .dr_hit   (dr_hit),
    .cs_attr  (cs_attr),
    .dr_attr  (dr_attr),
    .cs_out   (nxt_cs),
    .dr_out   (nxt_dr),
    .attr_out (nxt_attr),
    .undef    (nxt_undef)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_cs        <= '0;
      rsp_dram_sel  <= '0;
      rsp_port_size <= '0;
      rsp_burst_en  <= 1'b0;
      rsp_auto_ack  <= 1'b0;
      rsp_wait      <= '0;
      rsp_undef     <= 1'b0;
    end else if (take) begin
      rsp_valid     <= 1'b1;
      rsp_cs        <= nxt_cs;
      rsp_dram_sel  <= nxt_dr;
      rsp_port_size <= nxt_attr.port_size;
      rsp_burst_en  <= nxt_attr.burst;
      rsp_auto_ack  <= nxt_attr.auto_ack;
      rsp_wait      <= nxt_attr.wait_st;
      rsp_undef     <= nxt_undef;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/csd_decoder_sva.sv
module csd_decoder_sva #(
  parameter int N_CS   = 8,
  parameter int N_DRAM = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [N_CS-1:0]   rsp_cs,
  input logic [N_DRAM-1:0] rsp_dram_sel,
  input logic [1:0]        rsp_port_size,
  input logic              rsp_burst_en,
  input logic              rsp_auto_ack,
  input logic [3:0]        rsp_wait,
  input logic              rsp_undef
);
  // R8: an undefined cycle drives nothing
  a_r8_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_undef |-> rsp_cs == '0 && rsp_dram_sel == '0 &&
      rsp_port_size == 2'b00 && !rsp_burst_en && !rsp_auto_ack && rsp_wait == '0);

  // R7: at most one DRAM block, never together with a strobe
  a_r7_dram_alone: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_dram_sel) && !((|rsp_dram_sel) && (|rsp_cs)));

  // R6: several strobes force the external default attributes
  a_r6_multi_forced: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $countones(rsp_cs) > 1 |->
      rsp_port_size == 2'b00 && !rsp_burst_en && !rsp_auto_ack && rsp_wait == '0);

  // R4: no selection at all is an external 32-bit cycle
  a_r4_no_hit_external: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cs == '0 && rsp_dram_sel == '0 && !rsp_undef |->
      rsp_port_size == 2'b00 && !rsp_burst_en && !rsp_auto_ack && rsp_wait == '0);

  // R9: a stalled response holds every field
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_cs) && $stable(rsp_dram_sel) &&
      $stable(rsp_port_size) && $stable(rsp_burst_en) && $stable(rsp_auto_ack) &&
      $stable(rsp_wait) && $stable(rsp_undef));
endmodule

bind csd_decoder csd_decoder_sva #(.N_CS(N_CS), .N_DRAM(N_DRAM)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_cs        (rsp_cs),
  .rsp_dram_sel  (rsp_dram_sel),
  .rsp_port_size (rsp_port_size),
  .rsp_burst_en  (rsp_burst_en),
  .rsp_auto_ack  (rsp_auto_ack),
  .rsp_wait      (rsp_wait),
  .rsp_undef     (rsp_undef)
);

// File: tb/csd_decoder_tb.sv
`timescale 1ns/1ps
module csd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr_hi = '0;
  logic        req_write = 1'b0;
  logic        req_cpu_space = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_cs;
  logic [1:0]  rsp_dram_sel;
  logic [1:0]  rsp_port_size;
  logic        rsp_burst_en;
  logic        rsp_auto_ack;
  logic [3:0]  rsp_wait;
  logic        rsp_undef;

  int    checks = 0;
  int    errors = 0;
  string phase = "R11";
  bit    stall_mode = 1'b0;
  logic [7:0] lf = 8'h5A;

  always #10 clk = ~clk;

  csd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr_hi(req_addr_hi),
    .req_write(req_write), .req_cpu_space(req_cpu_space),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cs(rsp_cs),
    .rsp_dram_sel(rsp_dram_sel), .rsp_port_size(rsp_port_size),
    .rsp_burst_en(rsp_burst_en), .rsp_auto_ack(rsp_auto_ack),
    .rsp_wait(rsp_wait), .rsp_undef(rsp_undef)
  );

  // ---------------- reference model ----------------
  logic [15:0] m_base [10];
  logic [15:0] m_mask [10];
  logic [31:0] m_ctl  [10];
  bit          m_boot;
  bit          m_valid;
  logic [7:0]  m_cs;
  logic [1:0]  m_dr, m_ps;
  bit          m_burst, m_auto, m_undef;
  logic [3:0]  m_wait;

  task automatic model_eval(input logic [15:0] a, input bit w, input bit cpu);
    int   ncs = 0;
    int   nd = 0;
    int   one_cs = 0;
    int   one_d = 0;
    logic [7:0] hits = '0;
    logic [1:0] dh = '0;
    for (int i = 0; i < 10; i++) begin
      bit hit;
      if (i == 0 && m_boot) hit = !cpu;
      else begin
        hit = m_ctl[i][0] && (((a ^ m_base[i]) & ~m_mask[i]) == 16'h0);
        if (i < 8) begin
          if (cpu && !m_ctl[i][1]) hit = 0;
          if (w && m_ctl[i][2]) hit = 0;
        end else if (cpu) hit = 0;
      end
      if (hit) begin
        if (i < 8) begin ncs++; one_cs = i; hits[i] = 1'b1; end
        else begin nd++; one_d = i; dh[i-8] = 1'b1; end
      end
    end
    m_cs = '0; m_dr = '0; m_ps = 2'b00; m_burst = 0; m_auto = 0; m_wait = '0; m_undef = 0;
    if (nd == 0) begin
      m_cs = hits;
      if (ncs == 1) begin
        if (one_cs == 0 && m_boot) begin
          m_auto = 1; m_wait = 4'd15;
        end else begin
          m_ps = m_ctl[one_cs][5:4]; m_burst = m_ctl[one_cs][6];
          m_auto = m_ctl[one_cs][7]; m_wait = m_ctl[one_cs][11:8];
        end
      end
    end else if (nd == 1 && ncs == 0) begin
      m_dr = dh; m_ps = m_ctl[one_d][5:4]; m_burst = m_ctl[one_d][6]; m_auto = 1;
    end else begin
      m_undef = 1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) begin m_base[i] = '0; m_mask[i] = '0; m_ctl[i] = '0; end
      m_boot = 1; m_valid = 0;
    end else begin
      if (req_valid && (!m_valid || rsp_ready)) begin
        model_eval(req_addr_hi, req_write, req_cpu_space);
        m_valid = 1;
      end else if (rsp_ready) m_valid = 0;
      if (cfg_we && cfg_addr[4:1] < 4'd10) begin
        if (cfg_addr[0]) m_ctl[cfg_addr[4:1]] = cfg_wdata;
        else begin
          m_base[cfg_addr[4:1]] = cfg_wdata[31:16];
          m_mask[cfg_addr[4:1]] = cfg_wdata[15:0];
        end
        if (cfg_addr == 5'd1) m_boot = 0;
      end
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
        errors++;
        $display("FAIL R11: valid=%0b ready=%0b expected valid=0 ready=1", rsp_valid, req_ready);
      end
    end else begin
      bit bad;
      checks++;
      bad = (rsp_valid !== m_valid) || (req_ready !== (!m_valid || rsp_ready));
      if (m_valid)
        bad = bad || rsp_cs !== m_cs || rsp_dram_sel !== m_dr || rsp_port_size !== m_ps ||
              rsp_burst_en !== m_burst || rsp_auto_ack !== m_auto || rsp_wait !== m_wait ||
              rsp_undef !== m_undef;
      if (bad) begin
        errors++;
        $display("FAIL %s: got v=%0b rdy=%0b cs=%h dr=%b ps=%b b=%0b a=%0b w=%0d u=%0b expected v=%0b rdy=%0b cs=%h dr=%b ps=%b b=%0b a=%0b w=%0d u=%0b",
                 phase, rsp_valid, req_ready, rsp_cs, rsp_dram_sel, rsp_port_size, rsp_burst_en,
                 rsp_auto_ack, rsp_wait, rsp_undef, m_valid, (!m_valid || rsp_ready), m_cs, m_dr,
                 m_ps, m_burst, m_auto, m_wait, m_undef);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    rsp_ready = stall_mode ? lf[0] : 1'b1;
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] ctl(bit v, bit cpu, bit wp, logic [1:0] ps, bit b, bit a,
                                      logic [3:0] w);
    return {20'h0, w, a, b, ps, 1'b0, wp, cpu, v};
  endfunction

  task automatic cfg_write(input int win, input bit kind, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = {win[3:0], kind}; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [15:0] a, input bit w, input bit cpu);
    req_valid = 1'b1; req_addr_hi = a; req_write = w; req_cpu_space = cpu;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    phase = "R3";
    send(16'h1234, 0, 0);
    send(16'hFFFF, 1, 0);
    send(16'h0000, 0, 1);
    cfg_write(1, 0, 32'h1000_00FF);
    cfg_write(1, 1, ctl(1, 0, 0, 2'b01, 1, 1, 4'd3));
    send(16'h1005, 0, 0);
    cfg_write(0, 1, 32'h0);
    send(16'h5555, 0, 0);

    phase = "R4";
    send(16'h1234, 0, 0);
    send(16'h0000, 1, 1);

    phase = "R5";
    send(16'h1005, 0, 0);
    send(16'h10FF, 1, 0);
    send(16'h1100, 0, 0);

    phase = "R1";
    cfg_write(2, 0, 32'h2000_0000);
    cfg_write(2, 1, ctl(1, 0, 1, 2'b10, 0, 1, 4'd7));
    send(16'h2000, 0, 0);
    send(16'h2000, 1, 0);
    send(16'h2001, 0, 0);

    phase = "R2";
    cfg_write(4, 0, 32'hFFF0_000F);
    cfg_write(4, 1, ctl(1, 1, 0, 2'b10, 0, 1, 4'd1));
    send(16'hFFF3, 0, 1);
    send(16'hFFF3, 0, 0);
    send(16'h1005, 0, 1);

    phase = "R6";
    cfg_write(3, 0, 32'h1000_00FF);
    cfg_write(3, 1, ctl(1, 0, 0, 2'b10, 1, 1, 4'd9));
    send(16'h1010, 0, 0);
    send(16'h10F0, 1, 0);

    phase = "R7";
    cfg_write(8, 0, 32'h8000_0FFF);
    cfg_write(8, 1, ctl(1, 0, 0, 2'b10, 1, 0, 4'd0));
    send(16'h8123, 0, 0);
    send(16'h8123, 0, 1);

    phase = "R8";
    cfg_write(9, 0, 32'h8000_00FF);
    cfg_write(9, 1, ctl(1, 0, 0, 2'b01, 0, 0, 4'd0));
    send(16'h8010, 0, 0);
    send(16'h8200, 0, 0);
    cfg_write(5, 0, 32'h8000_0FFF);
    cfg_write(5, 1, ctl(1, 0, 0, 2'b01, 0, 1, 4'd2));
    send(16'h8500, 0, 0);
    send(16'h8010, 1, 0);

    phase = "R10";
    cfg_write(12, 1, 32'hFFFF_FFFF);
    cfg_write(15, 0, 32'h1234_0000);
    send(16'h1234, 0, 0);
    send(16'h2000, 0, 0);

    phase = "R9";
    stall_mode = 1'b1;
    for (int k = 0; k < 60; k++) begin
      logic [15:0] pick [6];
      pick[0] = 16'h1005; pick[1] = 16'h8500; pick[2] = 16'h2000;
      pick[3] = 16'hFFF3; pick[4] = 16'h8200; pick[5] = 16'h4444;
      send(pick[k % 6], k[0], (k % 5) == 0);
    end
    stall_mode = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9: watchdog expired, got no completion expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule